// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers a parameterized number of interrupt lines, 32 per bank and three banks by default, and turns them into two request outputs for a processor: a normal request and a fast request. Each source first goes through a synchronizer. Its pending state is then gated by a per-source enable bit and a per-source mask bit, and a priority encoder picks the lowest-numbered active source. Software reads that source's number, scaled by four, from a vector register.

Source 0 is the external input and is handled differently from the others. Its trigger can be set to one of four conditions: a level or an edge, of either polarity. Once triggered, it stays latched until software clears it by writing a one to its pending bit. Every other source simply follows its synchronized input level.

A protection switch limits register writes to privileged bus cycles. The block decodes 32-bit registers at byte addresses. A variant parameter moves the enable and mask register sets between two address bases.

Top module: `icu_vec_ctrl`

## Requirements
- R1: After reset, every enable bit, every mask bit, the protection bit and the trigger field are 0. The vector reads 0, and both `irq_o` and `fiq_o` are low.
- R2: The vector register at 0x00 reads the lowest-numbered pending, enabled and unmasked source, multiplied by 4. It reads 0 when no such source exists. When that source drops, a later read returns the next such source.
- R3: A source counts as active only while its enable bit is 1 and its mask bit is 0. Source n is bit n%32 of the bank n/32 register.
- R4: For sources 1 and up, the pending registers at 0x10+4·bank follow the synchronized input level. Writing to those bits has no effect.
- R5: Source 0 stays pending once triggered. Writing 1 to bit 0 of the pending register at 0x10 clears it, unless the trigger condition is still true in that cycle. Writing 0 has no effect.
- R6: The trigger field of source 0 is bits [1:0] of the register at 0x0c. The encodings are 0 = low level, 1 = high level, 2 = falling edge and 3 = rising edge. Edges are detected on the synchronized input.
- R7: Bit 0 of the register at 0x08 turns on protection. While it is 1, writes with `bus_priv` low change no register, including the protection bit itself. Privileged writes still take effect.
- R8: With `ALT_MAP`=0, the enable registers are at 0x40+4·bank and the mask registers are at 0x50+4·bank. With `ALT_MAP`=1 they are at 0x20+4·bank and 0x30+4·bank. Addresses that are not mapped read 0.
- R9: `irq_o` is high when any active source numbered 1 or above exists. `fiq_o` is high when source 0 is active. With `ALT_MAP`=0, bit 0 of the fast-pending register at 0x20 shows whether source 0 is active.
- R10: While source 0 is active, the vector reads 0, and bit 0 of the pending register at 0x10 reads 1. This tells an active source 0 apart from "nothing active".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Interrupt source lines; bit 0 is the external input |
| bus_addr | input | ADDR_W | Byte address of the register (word aligned) |
| bus_we | input | 1 | Write strobe |
| bus_priv | input | 1 | Current access is privileged |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request (source 0) |

## Verification
The hardest state to reach is source 0 meeting the vector register. The vector reads 0 both when source 0 is active and when nothing is active, while source 36 is also active and sits behind it. The stimulus builds this state in stages. It enables source 36, drives it, and then pulls the external input low in low-level mode. At that point the vector must read 0, the pending bit must read 1 and both outputs must be high. The bench then masks source 0 and checks that the vector moves to 36×4.

The edge modes are exercised by changing the trigger field while the input is held at a known level. This shows that a clear attempted while a level condition still holds is overridden. It also shows that holding the input high after a rising edge does not latch the source again.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int BANK_W = 32;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam int OFS_VECTOR  = 'h00;
  localparam int OFS_PROTECT = 'h08;
  localparam int OFS_EXTCTL  = 'h0c;
  localparam int OFS_PEND    = 'h10;
  localparam int OFS_FPEND   = 'h20;

  function automatic int enable_base(input bit alt);
    return alt ? 'h20 : 'h40;
  endfunction

  function automatic int mask_base(input bit alt);
    return alt ? 'h30 : 'h50;
  endfunction

endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= {W{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icu_src0_latch.sv
module icu_src0_latch
  import icu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  lvl_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q;
  logic hit;

  always_comb begin
    unique case (trig_i)
      TRIG_LOW:  hit = !lvl_i;
      TRIG_HIGH: hit = lvl_i;
      TRIG_FALL: hit = prev_q && !lvl_i;
      TRIG_RISE: hit = !prev_q && lvl_i;
      default:   hit = 1'b0;
    endcase
  end

  // A clear loses against a trigger condition in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_o <= hit || (pend_o && !clr_i);
    end
  end
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
  parameter int N  = 96,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/icu_vec_ctrl.sv
module icu_vec_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit ALT_MAP     = 1'b0,
  parameter int ADDR_W      = 8,
  localparam int NSRC       = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_priv,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int EN_BASE = enable_base(ALT_MAP);
  localparam int MK_BASE = mask_base(ALT_MAP);
  localparam int IW      = $clog2(NSRC);

  logic [NSRC-1:0] src_s, pend, gated, en_q, mask_q;
  logic            prot_q, p0, clr0, wr_ok, win_any;
  trig_e           trig_q;
  logic [IW-1:0]   win_idx;
  logic [31:0]     vec_q, rd_d;

  icu_sync #(.W(NSRC - 1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hi (
    .clk(clk), .rst(rst), .d_i(src_i[NSRC-1:1]), .q_o(src_s[NSRC-1:1]));

  icu_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ext (
    .clk(clk), .rst(rst), .d_i(src_i[0]), .q_o(src_s[0]));

  assign wr_ok = bus_we && (!prot_q || bus_priv);
  assign clr0  = wr_ok && (bus_addr == ADDR_W'(OFS_PEND)) && bus_wdata[0];

  icu_src0_latch u_ext (
    .clk(clk), .rst(rst), .lvl_i(src_s[0]), .trig_i(trig_q),
    .clr_i(clr0), .pend_o(p0));

  assign pend  = {src_s[NSRC-1:1], p0};
  assign gated = pend & en_q & ~mask_q;

  icu_prio #(.N(NSRC)) u_prio (.req_i(gated), .any_o(win_any), .idx_o(win_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '0;
      prot_q <= 1'b0;
      trig_q <= TRIG_LOW;
    end else if (wr_ok) begin
      if (bus_addr == ADDR_W'(OFS_PROTECT)) prot_q <= bus_wdata[0];
      if (bus_addr == ADDR_W'(OFS_EXTCTL))  trig_q <= trig_e'(bus_wdata[1:0]);
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == ADDR_W'(EN_BASE + 4 * b)) en_q[b*BANK_W +: BANK_W]   <= bus_wdata;
        if (bus_addr == ADDR_W'(MK_BASE + 4 * b)) mask_q[b*BANK_W +: BANK_W] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      vec_q <= win_any ? (32'(win_idx) << 2) : 32'd0;
      irq_o <= |gated[NSRC-1:1];
      fiq_o <= gated[0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == ADDR_W'(OFS_VECTOR))  rd_d = vec_q;
    if (bus_addr == ADDR_W'(OFS_PROTECT)) rd_d = {31'd0, prot_q};
    if (bus_addr == ADDR_W'(OFS_EXTCTL))  rd_d = {30'd0, trig_q};
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(OFS_PEND + 4 * b)) rd_d = pend[b*BANK_W +: BANK_W];
      if (!ALT_MAP && bus_addr == ADDR_W'(OFS_FPEND + 4 * b))
        rd_d = (b == 0) ? {31'd0, gated[0]} : 32'd0;
      if (bus_addr == ADDR_W'(EN_BASE + 4 * b)) rd_d = en_q[b*BANK_W +: BANK_W];
      if (bus_addr == ADDR_W'(MK_BASE + 4 * b)) rd_d = mask_q[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end
endmodule

// File: rtl/icu_vec_ctrl_chk.sv
module icu_vec_ctrl_chk #(
  parameter int NSRC = 96
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [31:0]     vec_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] mask_q,
  input logic            prot_q,
  input logic            bus_we,
  input logic            bus_priv,
  input logic            p0,
  input logic            clr0
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !fiq_o && vec_q == 32'd0 && en_q == '0 && mask_q == '0));

  // R2
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_q != 32'd0) |-> irq_o);

  // R7
  prot_block_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && bus_we && !bus_priv) |=> ($stable(en_q) && $stable(mask_q) && prot_q));

  // R5
  ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (p0 && !clr0) |=> p0);

  // R9
  fiq_source_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(p0));
endmodule

bind icu_vec_ctrl icu_vec_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o), .vec_q(vec_q),
  .en_q(en_q), .mask_q(mask_q), .prot_q(prot_q), .bus_we(bus_we),
  .bus_priv(bus_priv), .p0(p0), .clr0(clr0));

// File: tb/test_icu_vec_ctrl.sv
module test_icu_vec_ctrl;
  localparam int NSRC = 96;
  localparam int NV   = 78;
  // entry: op[78:77] (0 read, 1 write, 2 drive bank, 3 pins), addr[76:69],
  //        data[68:37], expect[36:5], priv[4], req[3:0]
  localparam logic [78:0] TBL [NV] = '{
    {2'd0, 8'h00, 32'h0, 32'h0, 1'b1, 4'd1},          // R1 vector
    {2'd0, 8'h40, 32'h0, 32'h0, 1'b1, 4'd1},          // R1 enable
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd1},          // R1 pending
    {2'd2, 8'h01, 32'h10, 32'h0, 1'b1, 4'd4},         // R4 source 36 high
    {2'd0, 8'h14, 32'h0, 32'h10, 1'b1, 4'd4},         // R4
    {2'd0, 8'h00, 32'h0, 32'h0, 1'b1, 4'd3},          // R3 not enabled
    {2'd1, 8'h44, 32'h10, 32'h0, 1'b1, 4'd3},         // R3
    {2'd0, 8'h00, 32'h0, 32'h90, 1'b1, 4'd2},         // R2 36*4
    {2'd1, 8'h54, 32'h10, 32'h0, 1'b1, 4'd3},         // R3 mask
    {2'd0, 8'h00, 32'h0, 32'h0, 1'b1, 4'd3},          // R3
    {2'd1, 8'h54, 32'h0, 32'h0, 1'b1, 4'd3},          // R3
    {2'd2, 8'h02, 32'h1, 32'h0, 1'b1, 4'd2},          // R2 source 64
    {2'd1, 8'h48, 32'h1, 32'h0, 1'b1, 4'd2},          // R2
    {2'd0, 8'h00, 32'h0, 32'h90, 1'b1, 4'd2},         // R2 lowest wins
    {2'd1, 8'h14, 32'hffffffff, 32'h0, 1'b1, 4'd4},   // R4 W1C ignored
    {2'd0, 8'h14, 32'h0, 32'h10, 1'b1, 4'd4},         // R4
    {2'd2, 8'h01, 32'h0, 32'h0, 1'b1, 4'd2},          // R2
    {2'd0, 8'h00, 32'h0, 32'h100, 1'b1, 4'd2},        // R2 next source
    {2'd2, 8'h02, 32'h0, 32'h0, 1'b1, 4'd2},          // R2
    {2'd0, 8'h00, 32'h0, 32'h0, 1'b1, 4'd2},          // R2 none
    {2'd1, 8'h40, 32'h1, 32'h0, 1'b1, 4'd10},         // R10
    {2'd2, 8'h00, 32'h0, 32'h0, 1'b1, 4'd10},         // R10 ext low
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd10},         // R10
    {2'd0, 8'h00, 32'h0, 32'h0, 1'b1, 4'd10},         // R10
    {2'd2, 8'h00, 32'h1, 32'h0, 1'b1, 4'd5},          // R5 release
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd5},          // R5 latched
    {2'd1, 8'h10, 32'h0, 32'h0, 1'b1, 4'd5},          // R5 write 0
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd5},          // R5
    {2'd1, 8'h10, 32'h1, 32'h0, 1'b1, 4'd5},          // R5 clear
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd5},          // R5
    {2'd1, 8'h0c, 32'h3, 32'h0, 1'b1, 4'd6},          // R6 rising
    {2'd0, 8'h0c, 32'h0, 32'h3, 1'b1, 4'd6},          // R6
    {2'd2, 8'h00, 32'h0, 32'h0, 1'b1, 4'd6},          // R6 fall
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd6},          // R6
    {2'd2, 8'h00, 32'h1, 32'h0, 1'b1, 4'd6},          // R6 rise
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd6},          // R6
    {2'd1, 8'h10, 32'h1, 32'h0, 1'b1, 4'd6},          // R6
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd6},          // R6 held high
    {2'd1, 8'h0c, 32'h1, 32'h0, 1'b1, 4'd6},          // R6 high level
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd6},          // R6
    {2'd1, 8'h10, 32'h1, 32'h0, 1'b1, 4'd6},          // R6
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd6},          // R6 level holds
    {2'd1, 8'h0c, 32'h2, 32'h0, 1'b1, 4'd6},          // R6 falling
    {2'd1, 8'h10, 32'h1, 32'h0, 1'b1, 4'd6},          // R6
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd6},          // R6
    {2'd2, 8'h00, 32'h0, 32'h0, 1'b1, 4'd6},          // R6
    {2'd0, 8'h10, 32'h0, 32'h1, 1'b1, 4'd6},          // R6
    {2'd1, 8'h10, 32'h1, 32'h0, 1'b1, 4'd6},          // R6
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd6},          // R6 low held
    {2'd2, 8'h00, 32'h1, 32'h0, 1'b1, 4'd6},          // R6
    {2'd1, 8'h0c, 32'h0, 32'h0, 1'b1, 4'd6},          // R6 low level
    {2'd0, 8'h10, 32'h0, 32'h0, 1'b1, 4'd6},          // R6
    {2'd1, 8'h08, 32'h1, 32'h0, 1'b1, 4'd7},          // R7 protect on
    {2'd0, 8'h08, 32'h0, 32'h1, 1'b1, 4'd7},          // R7
    {2'd1, 8'h44, 32'hff, 32'h0, 1'b0, 4'd7},         // R7 user write
    {2'd0, 8'h44, 32'h0, 32'h10, 1'b1, 4'd7},         // R7 unchanged
    {2'd1, 8'h44, 32'hff, 32'h0, 1'b1, 4'd7},         // R7 priv write
    {2'd0, 8'h44, 32'h0, 32'hff, 1'b1, 4'd7},         // R7
    {2'd1, 8'h08, 32'h0, 32'h0, 1'b0, 4'd7},          // R7
    {2'd0, 8'h08, 32'h0, 32'h1, 1'b1, 4'd7},          // R7 still on
    {2'd1, 8'h08, 32'h0, 32'h0, 1'b1, 4'd7},          // R7
    {2'd0, 8'h08, 32'h0, 32'h0, 1'b1, 4'd7},          // R7
    {2'd3, 8'h00, 32'h0, 32'h0, 1'b1, 4'd9},          // R9 idle
    {2'd2, 8'h01, 32'h10, 32'h0, 1'b1, 4'd9},         // R9
    {2'd3, 8'h00, 32'h0, 32'h1, 1'b1, 4'd9},          // R9 irq
    {2'd2, 8'h00, 32'h0, 32'h0, 1'b1, 4'd9},          // R9
    {2'd3, 8'h00, 32'h0, 32'h3, 1'b1, 4'd9},          // R9 both
    {2'd0, 8'h20, 32'h0, 32'h1, 1'b1, 4'd9},          // R9 fast pend
    {2'd0, 8'h00, 32'h0, 32'h0, 1'b1, 4'd10},         // R10 src0 wins
    {2'd1, 8'h50, 32'h1, 32'h0, 1'b1, 4'd3},          // R3 mask ext
    {2'd3, 8'h00, 32'h0, 32'h1, 1'b1, 4'd3},          // R3
    {2'd0, 8'h20, 32'h0, 32'h0, 1'b1, 4'd9},          // R9
    {2'd0, 8'h00, 32'h0, 32'h90, 1'b1, 4'd2},         // R2
    {2'd2, 8'h00, 32'h1, 32'h0, 1'b1, 4'd5},          // R5
    {2'd1, 8'h10, 32'h1, 32'h0, 1'b1, 4'd5},          // R5
    {2'd1, 8'h50, 32'h0, 32'h0, 1'b1, 4'd3},          // R3
    {2'd3, 8'h00, 32'h0, 32'h1, 1'b1, 4'd9},          // R9
    {2'd0, 8'h48, 32'h0, 32'h1, 1'b1, 4'd8}           // R8 default map
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic [NSRC-1:0] src_b;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_priv = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_b;
  logic        irq, fiq, irq_b, fiq_b;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int wd = 0;

  always #2 clk = ~clk;

  assign src_b = {{(NSRC - 6){1'b0}}, 6'b100001};

  icu_vec_ctrl i_icu_vec_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_priv(bus_priv), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq));

  icu_vec_ctrl #(.ALT_MAP(1'b1)) i_icu_vec_ctrl_alt (
    .clk(clk), .rst(rst), .src_i(src_b), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_priv(bus_priv), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .irq_o(irq_b), .fiq_o(fiq_b));

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got 0x%08h, expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vb);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1;
    v  = rdata;
    vb = rdata_b;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_priv = 1'b1;
    settle();
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vb;
    src[0] = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 pins after reset
    check(1, {30'd0, fiq, irq}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      logic        p;
      int          rq;
      op = TBL[k][78:77];
      a  = TBL[k][76:69];
      d  = TBL[k][68:37];
      e  = TBL[k][36:5];
      p  = TBL[k][4];
      rq = int'(TBL[k][3:0]);
      case (op)
        2'd0: begin bus_rd(a, v, vb); check(rq, v, e); end
        2'd1: bus_wr(a, d, p);
        2'd2: begin
          @(negedge clk);
          src[int'(a)*32 +: 32] = d;
          settle();
        end
        default: begin
          @(negedge clk);
          check(rq, {30'd0, fiq, irq}, e);
        end
      endcase
    end

    // R8 alternate map: enable at 0x20, mask at 0x30, 0x40 unmapped
    bus_wr(8'h20, 32'h20, 1'b1);
    bus_rd(8'h20, v, vb);
    check(8, vb, 32'h20);
    bus_rd(8'h00, v, vb);
    check(8, vb, 32'h14);
    bus_rd(8'h40, v, vb);
    check(8, vb, 32'h0);
    bus_wr(8'h30, 32'h20, 1'b1);
    bus_rd(8'h00, v, vb);
    check(8, vb, 32'h0);

    // R1 reset in the middle of activity
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    settle();
    bus_rd(8'h44, v, vb);
    check(1, v, 32'h0);
    bus_rd(8'h0c, v, vb);
    check(1, v, 32'h0);
    check(1, {30'd0, fiq, irq}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule